// File: doc/BRIEF.md
# Tower Sample Capture and Replay Buffer

This block keeps a short circular history of calorimeter trigger-tower samples, one 128-bit record per tower for each of a run of bunch crossings. In spy mode it writes the record arriving on the algorithm side into the slot named by a crossing pointer on every clock, together with the crossing ID of that cycle. In playback mode it reads the slot at the pointer and drives the stored record back toward the algorithm. An idle mode leaves the pointer and the storage untouched. A one-cycle restart pulse returns the pointer to slot 0, so that a capture or a replay can be lined up with a chosen crossing.

A 32-bit register-bus port reaches the same storage. Each 128-bit slot is seen there as four consecutive 32-bit words. The top two bits of every word carry the word's position inside its slot, and the last word of a slot also returns the stored crossing ID. Bus writes are cleaned before they are stored: tag and padding positions are dropped. Each tower keeps its own memory, and the number of towers is a parameter.

Top module: `spyPlaybackRam`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `algoOut` and `busRdata` are zero and the crossing pointer is 0.
- R2: For bus quarters 0, 1 and 2, the word read back is the quarter index in [31:30] above the 30 stored bits of that quarter. On a write, [31:30] are ignored and do not reach the storage.
- R3: Bus quarter 3 reads as {2'b11, crossing ID[6:0], 3'b000, HAD[9:0], L3[9:0]}. Written bits [22:20] are ignored, and written bits [29:23] become the stored crossing ID.
- R4: Bus address bits [1:0] pick the quarter, bits [5:2] the slot, and the bits above them the tower. A tower index equal to or above the tower count reads as zero, and writes to it are dropped.
- R5: `busRdata` shows, one clock after the edge, the word at the address that was presented on that edge. Any address can be read on any cycle.
- R6: In spy mode (`mode` = 2'b01) the slot at the pointer takes `algoIn` with its padding cleared and `bcId` placed in record bits [126:120]. The pointer then steps by one and wraps from 15 to 0.
- R7: In playback mode (`mode` = 2'b10) `algoOut` shows, one cycle later, the record at the pointer with every padding bit zero, the crossing ID bits included. The pointer then steps by one and wraps.
- R8: In idle mode (`mode` = 2'b00 or 2'b11) the pointer holds and nothing is written from the algorithm side. `algoOut` is zero in the cycle after any cycle without a replay.
- R9: A `restart` pulse sets the pointer to 0 and overrides the mode for that cycle: it captures nothing and replays nothing.
- R10: If a spy write and a bus write hit the same slot in one cycle, the bus write decides its own quarter and the spy record fills the other three.
- R11: A bus read that coincides with a write to the same slot returns the contents from before that write.
- R12: Record layout: L0 [9:0], L1.0 [19:10], L1.1 [29:20], L1.2 [41:32], L1.3 [51:42], L2.0 [61:52], L2.1 [73:64], L2.2 [83:74], L2.3 [93:84], L3 [105:96], HAD [115:106]. All other bits are padding, and bus quarter q maps to record bits [32q+31:32q].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 2 | 00/11 idle, 01 spy, 10 playback |
| restart | input | 1 | One-cycle pulse that sets the crossing pointer to 0 |
| bcId | input | 7 | Crossing ID stored with each spy record |
| algoIn | input | NUM_TOWERS*128 | Algorithm-side records, tower t at bits [128t+127:128t] |
| algoOut | output | NUM_TOWERS*128 | Replayed records, padding forced to zero |
| busAddr | input | TSEL_W+6 | Bus word address {tower, slot, quarter} |
| busWe | input | 1 | Bus write strobe |
| busWdata | input | 32 | Bus write data |
| busRdata | output | 32 | Registered bus read data |

## Verification
An algorithm-side capture and a bus access can land on the same slot in the same cycle. The bench provokes this by holding spy mode while it writes one quarter, or reads a quarter, of the slot under the pointer. It then reads that slot back. The written quarter must carry the bus data and the other quarters the spy record. A read made in that same cycle must return the data from before the write.

// File: rtl/twrPkg.sv
`timescale 1ns/1ps
package twrPkg;
  localparam int REC_W    = 128;
  localparam int WORD_W   = 32;
  localparam int QUARTERS = REC_W / WORD_W;
  localparam int BCID_W   = 7;
  localparam int BCID_LSB = 120;

  localparam logic [1:0] MODE_IDLE = 2'b00;
  localparam logic [1:0] MODE_SPY  = 2'b01;
  localparam logic [1:0] MODE_PLAY = 2'b10;

  // positions of the eleven 10-bit samples inside a record
  localparam logic [REC_W-1:0] DATA_MASK = {12'h000, 20'hFFFFF,
                                            2'b00, 30'h3FFF_FFFF,
                                            2'b00, 30'h3FFF_FFFF,
                                            2'b00, 30'h3FFF_FFFF};

  typedef struct packed {
    logic capture;
    logic replay;
  } ctrlStrobe_t;

  // bus word -> stored quarter (tags and padding dropped)
  function automatic logic [WORD_W-1:0] toStore(input logic [1:0] q, input logic [WORD_W-1:0] w);
    logic [WORD_W-1:0] s;
    if (q == 2'd3) s = {1'b0, w[29:23], 4'b0000, w[19:0]};
    else           s = {2'b00, w[29:0]};
    return s;
  endfunction

  // stored quarter -> bus word (tag inserted)
  function automatic logic [WORD_W-1:0] toBus(input logic [1:0] q, input logic [WORD_W-1:0] s);
    logic [WORD_W-1:0] w;
    if (q == 2'd3) w = {2'b11, s[30:24], 3'b000, s[19:0]};
    else           w = {q, s[29:0]};
    return w;
  endfunction
endpackage

// File: rtl/spCtrl.sv
`timescale 1ns/1ps
module spCtrl
  import twrPkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode,
  input  logic             restart,
  output ctrlStrobe_t      strb,
  output logic [PTR_W-1:0] ptr
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  always_comb begin
    strb.capture = !restart && (mode == MODE_SPY);
    strb.replay  = !restart && (mode == MODE_PLAY);
  end

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      ptr <= '0;
    end else if (strb.capture || strb.replay) begin
      ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
    end
  end
endmodule

// File: rtl/spData.sv
`timescale 1ns/1ps
module spData
  import twrPkg::*;
#(
  parameter int NUM_TOWERS = 60,
  parameter int DEPTH      = 16,
  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int TSEL_W = (NUM_TOWERS > 1) ? $clog2(NUM_TOWERS) : 1,
  localparam int BUS_W  = NUM_TOWERS * REC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobe_t       strb,
  input  logic [PTR_W-1:0]  ptr,
  input  logic [BUS_W-1:0]  algoIn,
  input  logic [BCID_W-1:0] bcId,
  input  logic [TSEL_W-1:0] busTower,
  input  logic [PTR_W-1:0]  busEntry,
  input  logic [1:0]        busQuarter,
  input  logic              busWe,
  input  logic [WORD_W-1:0] busWdata,
  output logic [BUS_W-1:0]  algoOut,
  output logic [WORD_W-1:0] busRdata
);
  logic [WORD_W-1:0] rdWord [NUM_TOWERS];
  logic [WORD_W-1:0] storeWord;
  logic [REC_W-1:0]  bcIdField;

  assign storeWord = toStore(busQuarter, busWdata);
  assign bcIdField = REC_W'(bcId) << BCID_LSB;

  for (genvar t = 0; t < NUM_TOWERS; t++) begin : g_tower
    logic [REC_W-1:0] mem [DEPTH];
    logic [REC_W-1:0] spyRec;
    logic             busHit;

    assign spyRec = (algoIn[t*REC_W +: REC_W] & DATA_MASK) | bcIdField;
    assign busHit = busWe && (busTower == TSEL_W'(t));

    // spy record first, bus quarter last: bus wins its quarter
    always_ff @(posedge clk) begin
      if (strb.capture) mem[ptr] <= spyRec;
      if (busHit) mem[busEntry][busQuarter*WORD_W +: WORD_W] <= storeWord;
    end

    assign rdWord[t] = toBus(busQuarter, mem[busEntry][busQuarter*WORD_W +: WORD_W]);

    always_ff @(posedge clk) begin
      if (rst || !strb.replay) algoOut[t*REC_W +: REC_W] <= '0;
      else                     algoOut[t*REC_W +: REC_W] <= mem[ptr] & DATA_MASK;
    end
  end

  logic [WORD_W-1:0] rdNext;
  always_comb begin
    rdNext = '0;
    for (int t = 0; t < NUM_TOWERS; t++) begin
      if (busTower == TSEL_W'(t)) rdNext = rdWord[t];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) busRdata <= '0;
    else     busRdata <= rdNext;
  end
endmodule

// File: rtl/spyPlaybackRam.sv
`timescale 1ns/1ps
module spyPlaybackRam
  import twrPkg::*;
#(
  parameter int NUM_TOWERS = 60,
  parameter int DEPTH      = 16,
  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int TSEL_W = (NUM_TOWERS > 1) ? $clog2(NUM_TOWERS) : 1,
  localparam int ADDR_W = TSEL_W + PTR_W + 2,
  localparam int BUS_W  = NUM_TOWERS * 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        mode,
  input  logic              restart,
  input  logic [6:0]        bcId,
  input  logic [BUS_W-1:0]  algoIn,
  output logic [BUS_W-1:0]  algoOut,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata
);
  ctrlStrobe_t      strb;
  logic [PTR_W-1:0] ptr;

  spCtrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst), .mode(mode), .restart(restart),
    .strb(strb), .ptr(ptr)
  );

  spData #(.NUM_TOWERS(NUM_TOWERS), .DEPTH(DEPTH)) u_data (
    .clk(clk), .rst(rst), .strb(strb), .ptr(ptr),
    .algoIn(algoIn), .bcId(bcId),
    .busTower(busAddr[ADDR_W-1 -: TSEL_W]),
    .busEntry(busAddr[PTR_W+1:2]),
    .busQuarter(busAddr[1:0]),
    .busWe(busWe), .busWdata(busWdata),
    .algoOut(algoOut), .busRdata(busRdata)
  );
endmodule

// File: rtl/spyPlaybackRam_chk.sv
`timescale 1ns/1ps
module spyPlaybackRam_chk
  import twrPkg::*;
#(
  parameter int NUM_TOWERS = 60,
  parameter int DEPTH      = 16,
  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int TSEL_W = (NUM_TOWERS > 1) ? $clog2(NUM_TOWERS) : 1,
  localparam int ADDR_W = TSEL_W + PTR_W + 2,
  localparam int BUS_W  = NUM_TOWERS * 128
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        mode,
  input logic              restart,
  input logic [ADDR_W-1:0] busAddr,
  input logic [31:0]       busRdata,
  input logic [BUS_W-1:0]  algoOut,
  input logic [PTR_W-1:0]  ptr
);
  logic [TSEL_W-1:0] tower;
  logic              towerOk;
  logic              stepping;
  assign tower    = busAddr[ADDR_W-1 -: TSEL_W];
  assign towerOk  = int'(tower) < NUM_TOWERS;
  assign stepping = !restart && (mode == MODE_SPY || mode == MODE_PLAY);

  // R1
  rstOut_chk: assert property (@(posedge clk) rst |=> (algoOut == '0 && busRdata == '0 && ptr == '0));

  // R9
  restartPtr_chk: assert property (@(posedge clk) disable iff (rst) restart |=> ptr == '0);

  // R6
  ptrStep_chk: assert property (@(posedge clk) disable iff (rst)
    stepping |=> int'(ptr) == ((int'($past(ptr)) + 1) % DEPTH));

  // R8
  ptrHold_chk: assert property (@(posedge clk) disable iff (rst)
    (!restart && !stepping) |=> $stable(ptr));

  // R8
  idleOut_chk: assert property (@(posedge clk) disable iff (rst)
    (restart || mode != MODE_PLAY) |=> algoOut == '0);

  // R2
  busTag_chk: assert property (@(posedge clk) disable iff (rst)
    towerOk |=> busRdata[31:30] == $past(busAddr[1:0]));

  // R4
  badTower_chk: assert property (@(posedge clk) disable iff (rst)
    !towerOk |=> busRdata == '0);

  // R3
  lastGap_chk: assert property (@(posedge clk) disable iff (rst)
    (towerOk && busAddr[1:0] == 2'd3) |=> busRdata[22:20] == 3'b000);

  for (genvar t = 0; t < NUM_TOWERS; t++) begin : g_pad
    // R7
    padZero_chk: assert property (@(posedge clk) disable iff (rst)
      (algoOut[t*128 +: 128] & ~DATA_MASK) == '0);
  end
endmodule

bind spyPlaybackRam spyPlaybackRam_chk #(.NUM_TOWERS(NUM_TOWERS), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .mode(mode), .restart(restart), .busAddr(busAddr),
  .busRdata(busRdata), .algoOut(algoOut), .ptr(ptr)
);

// File: tb/spyPlaybackRam_bench.sv
`timescale 1ns/1ps
module spyPlaybackRam_bench;
  localparam int NT = 3;
  localparam int AW = 8;
  localparam logic [127:0] MASK = {12'h000, 20'hFFFFF, 2'b00, 30'h3FFF_FFFF,
                                   2'b00, 30'h3FFF_FFFF, 2'b00, 30'h3FFF_FFFF};

  logic clk = 0;
  logic rst = 1;
  logic [1:0] mode = 2'b00;
  logic restart = 0;
  logic [6:0] bcId = '0;
  logic [NT*128-1:0] algoIn = '0;
  logic [NT*128-1:0] algoOut;
  logic [AW-1:0] busAddr = '0;
  logic busWe = 0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;

  int runCount = 0;
  int failCount = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  spyPlaybackRam #(.NUM_TOWERS(NT), .DEPTH(16)) u_spyPlaybackRam (
    .clk(clk), .rst(rst), .mode(mode), .restart(restart), .bcId(bcId),
    .algoIn(algoIn), .algoOut(algoOut), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata)
  );

  // vector table: {addr, write data, expected read}, one write then one read each
  localparam int NV = 7;
  localparam logic [AW-1:0] V_ADDR [NV] = '{8'h00, 8'h55, 8'hBE, 8'h0F, 8'hC0, 8'h57, 8'h90};
  localparam logic [31:0]   V_WR   [NV] = '{32'hFFFF_FFFF, 32'h0000_0001, 32'h1234_5678,
                                           32'hFFFF_FFFF, 32'hAAAA_AAAA, 32'h0070_0000, 32'hC000_0123};
  localparam logic [31:0]   V_EXP  [NV] = '{32'h3FFF_FFFF, // R2 tag bits dropped on write
                                           32'h4000_0001, // R2 quarter 1
                                           32'h9234_5678, // R2 quarter 2
                                           32'hFF8F_FFFF, // R3 gap cleared, crossing ID kept
                                           32'h0000_0000, // R4 tower beyond count
                                           32'hC000_0000, // R3 gap only
                                           32'h0000_0123};// R2 tag bits ignored
  localparam int            V_REQ  [NV] = '{2, 2, 2, 3, 4, 3, 2};

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    runCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [AW-1:0] a, input logic [31:0] d);
    busAddr = a; busWdata = d; busWe = 1; step(); busWe = 0;
  endtask

  task automatic busRead(input logic [AW-1:0] a, output logic [31:0] d);
    busAddr = a; step(); d = busRdata;
  endtask

  function automatic logic [127:0] mkRec(input int k, input int t);
    logic [31:0] w;
    w = 32'hC3A5_0000 | 32'(k << 8) | 32'(t);
    return {4{w}};
  endfunction

  function automatic logic [31:0] expWord(input logic [127:0] rec, input logic [6:0] id, input int q);
    logic [127:0] e;
    e = rec & MASK;
    if (q == 3) return {2'b11, id, 3'b000, e[115:96]};
    return {2'(q), e[q*32 +: 30]};
  endfunction

  function automatic logic [AW-1:0] addrOf(input int t, input int e, input int q);
    return {2'(t), 4'(e), 2'(q)};
  endfunction

  // slot contents after the spy runs below
  function automatic int kOfSlot(input int e);
    if (e == 0) return 16;
    if (e == 1) return 17;
    if (e == 2) return 40;
    return e;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      failCount++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("[TB] %0d tests run, %0d failed", runCount, failCount);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    step(); step();
    check("R1 algoOut in reset", algoOut, '0);
    check("R1 busRdata in reset", 128'(busRdata), '0);
    rst = 0;

    // table walk
    for (int i = 0; i < NV; i++) begin
      busWrite(V_ADDR[i], V_WR[i]);
      busRead(V_ADDR[i], rd);
      runCount++;
      if (rd !== V_EXP[i]) begin
        failCount++;
        $display("FAIL R%0d vector %0d: actual %h expected %h", V_REQ[i], i, rd, V_EXP[i]);
      end
    end

    // R12 / R7: bus-built slot replayed to the algorithm side
    busWrite(addrOf(0, 0, 0), 32'h3FFF_FFFF);
    busWrite(addrOf(0, 0, 1), 32'h0000_0000);
    busWrite(addrOf(0, 0, 2), 32'h0ABC_DEF0);
    busWrite(addrOf(0, 0, 3), 32'h3FFF_FFFF);
    restart = 1; mode = 2'b10; step(); restart = 0;
    check("R9 no replay in restart cycle", algoOut[127:0], '0);
    step();
    check("R12 record layout via playback", algoOut[127:0],
          {32'h000F_FFFF, 32'h0ABC_DEF0, 32'h0000_0000, 32'h3FFF_FFFF});
    mode = 2'b00; step();

    // R6: spy run of 18 crossings, wraps over slots 0 and 1
    restart = 1; mode = 2'b01; step(); restart = 0;
    for (int k = 0; k < 18; k++) begin
      for (int t = 0; t < NT; t++) algoIn[t*128 +: 128] = mkRec(k, t);
      bcId = 7'(k + 1);
      step();
    end
    mode = 2'b00;
    for (int q = 0; q < 4; q++) begin
      busRead(addrOf(2, 0, q), rd);
      check("R6 wrapped slot 0", 128'(rd), 128'(expWord(mkRec(16, 2), 7'd17, q)));
    end
    busRead(addrOf(2, 1, 3), rd);
    check("R6 wrapped slot 1", 128'(rd), 128'(expWord(mkRec(17, 2), 7'd18, 3)));
    busRead(addrOf(0, 15, 3), rd);
    check("R6 slot 15", 128'(rd), 128'(expWord(mkRec(15, 0), 7'd16, 3)));
    busRead(addrOf(1, 5, 1), rd);
    check("R6 slot 5", 128'(rd), 128'(expWord(mkRec(5, 1), 7'd6, 1)));

    // R8: idle holds pointer and writes nothing
    for (int t = 0; t < NT; t++) algoIn[t*128 +: 128] = mkRec(99, t);
    step(); step(); step();
    check("R8 algoOut zero when idle", algoOut, '0);
    busRead(addrOf(1, 3, 1), rd);
    check("R8 idle did not write", 128'(rd), 128'(expWord(mkRec(3, 1), 7'd4, 1)));
    for (int t = 0; t < NT; t++) algoIn[t*128 +: 128] = mkRec(40, t);
    bcId = 7'd41; mode = 2'b01; step(); mode = 2'b00;
    busRead(addrOf(1, 2, 0), rd);
    check("R8 pointer held at slot 2", 128'(rd), 128'(expWord(mkRec(40, 1), 7'd41, 0)));

    // R7: playback across the wrap
    restart = 1; mode = 2'b10; step(); restart = 0;
    for (int n = 0; n < 17; n++) begin
      step();
      for (int t = 0; t < NT; t++)
        check("R7 playback record", algoOut[t*128 +: 128], mkRec(kOfSlot(n % 16), t) & MASK);
    end
    mode = 2'b00; step();
    check("R8 algoOut zero after playback", algoOut, '0);

    // R10: spy and bus write on the same slot in one cycle
    restart = 1; step(); restart = 0;
    for (int t = 0; t < NT; t++) algoIn[t*128 +: 128] = mkRec(50, t);
    bcId = 7'd51; mode = 2'b01;
    busAddr = addrOf(1, 0, 1); busWdata = 32'h0000_0ABC; busWe = 1;
    step(); busWe = 0; mode = 2'b00;
    busRead(addrOf(1, 0, 1), rd);
    check("R10 bus quarter wins", 128'(rd), 128'(32'h4000_0ABC));
    busRead(addrOf(1, 0, 0), rd);
    check("R10 spy fills other quarter", 128'(rd), 128'(expWord(mkRec(50, 1), 7'd51, 0)));

    // R11 / R5: read during a spy write to the same slot returns old data
    restart = 1; step(); restart = 0;
    for (int t = 0; t < NT; t++) algoIn[t*128 +: 128] = mkRec(60, t);
    bcId = 7'd61; mode = 2'b01; busAddr = addrOf(2, 0, 2);
    step(); mode = 2'b00; rd = busRdata;
    check("R11 read-before-write", 128'(rd), 128'(expWord(mkRec(50, 2), 7'd51, 2)));
    step();
    check("R5 next read shows new data", 128'(busRdata), 128'(expWord(mkRec(60, 2), 7'd61, 2)));

    // R9: restart overrides spy mode
    for (int t = 0; t < NT; t++) algoIn[t*128 +: 128] = mkRec(70, t);
    restart = 1; mode = 2'b01; step(); restart = 0; mode = 2'b00;
    busRead(addrOf(0, 1, 0), rd);
    check("R9 no capture at old pointer", 128'(rd), 128'(expWord(mkRec(17, 0), 7'd18, 0)));
    busRead(addrOf(0, 0, 0), rd);
    check("R9 no capture at slot 0", 128'(rd), 128'(expWord(mkRec(60, 0), 7'd61, 0)));

    $display("[TB] %0d tests run, %0d failed", runCount, failCount);
    $finish;
  end
endmodule